// File: doc/BRIEF.md
# Dual-Width Serial Header CRC Generator

This block computes a short cyclic redundancy check over a wireless-LAN signal-field header that arrives one bit per clock. The message is framed by a start strobe and an end strobe, and each message bit is qualified by a valid strobe. A mode input picks one of two check widths, each with its own polynomial: an 8-bit check using x^8 + x^2 + x + 1, or a 4-bit check using x^4 + x + 1. One remainder register serves both widths. In the narrow mode only its low four bits are live.

The register is preset to all ones when a message starts. It absorbs each accepted bit. When the message ends, its content is inverted and the result is shifted out serially, most significant bit first. The output carries a valid flag and a last flag. While the check bits are leaving, the block drops its ready output and ignores every framing and data input. A new message may start once the final check bit has been presented. Messages may be of any length, including zero. Idle gaps between bits are allowed.

Top module: `sig_crc_serial`

## Requirements
- R1: With `mode_short`=0 the check value is the 8-bit remainder of polynomial taps 0x07, with a preset of 0xFF and a final XOR with 0xFF. It is emitted as 8 bits.
- R2: With `mode_short`=1 the check value is the 4-bit remainder of polynomial taps 0x3, with a preset of 0xF and a final XOR with 0xF. It is emitted as 4 bits.
- R3: Check bits leave on `crc_bit` in consecutive cycles, most significant first, with `crc_valid` high throughout. `crc_last` is high only on the final bit, and `crc_valid` falls in the next cycle.
- R4: `crc_valid` rises in the cycle right after the clock edge that accepts `msg_end`. A data bit that carries `msg_valid` in that same cycle is part of the message.
- R5: While `crc_valid` is high, `in_ready` is low, and `msg_start`, `msg_valid`, `msg_end` and `msg_bit` have no effect on the emitted value or on the block's state.
- R6: A data bit presented with `msg_valid` in the same cycle as `msg_start` is the first bit of the new message.
- R7: An empty message (`msg_start` and `msg_end` together, no valid bit) yields an all-zero check value.
- R8: A `msg_start` during an open message discards the bits absorbed so far and presets the register again.
- R9: After a synchronous active-low reset, and in idle without a start, `in_ready` is high and `crc_valid` is low. `msg_valid` and `msg_end` without a start do not produce output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_short | input | 1 | 0: 8-bit check, 1: 4-bit check; held from start to last check bit |
| msg_start | input | 1 | Opens a message and presets the remainder |
| msg_valid | input | 1 | Qualifies `msg_bit` |
| msg_bit | input | 1 | Message data bit |
| msg_end | input | 1 | Closes the message |
| in_ready | output | 1 | High when framing and data inputs are accepted |
| crc_valid | output | 1 | A check bit is on `crc_bit` |
| crc_bit | output | 1 | Serial check value, MSB first |
| crc_last | output | 1 | Final check bit of the value |

## Verification
Every message result is compared against a bench model that steps the same polynomial bit by bit, in both modes. Empty and single-bit messages isolate the preset and the final inversion, because their results follow from those alone. A 24-bit header shows that the feedback taps are right over a full header. Random lengths up to 64 bits, some with idle gaps, show that only qualified bits count. Directed runs drive start, valid and end while the output is busy, restart an open message, and send stray end strobes in idle. These runs tell a block that honours its framing apart from one that leaks inputs into the remainder.

// File: rtl/sigcrc_pkg.sv
// Shared types for the serial header CRC generator.
// Assumes nothing beyond a single clock domain.
package sigcrc_pkg;

    // Framing state of the message controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_SEND  = 2'd2
    } frame_state_t;

endpackage

// File: rtl/sigcrc_ctrl.sv
// Message framing controller. It decides which input strobes are accepted,
// latches the mode at the start of a message, and hands control to the
// serializer when the message ends. It assumes that ser_last marks the
// cycle in which the final check bit is presented.
module sigcrc_ctrl
    import sigcrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in,
    input  logic msg_start,
    input  logic msg_valid,
    input  logic msg_end,
    input  logic ser_last,
    output logic accept,
    output logic start_acc,
    output logic step_en,
    output logic end_acc,
    output logic mode_eff
);

    frame_state_t state_q, state_d;
    logic         mode_q;
    logic         open_msg;

    // Acceptance decode for the current cycle.
    always_comb begin
        accept    = (state_q != ST_SEND);
        start_acc = accept && msg_start;
        open_msg  = start_acc || (state_q == ST_ACCUM);
        step_en   = open_msg && msg_valid;
        end_acc   = open_msg && msg_end;
        mode_eff  = start_acc ? mode_in : mode_q;
    end

    // Next-state selection for framing.
    always_comb begin
        state_d = state_q;
        if (state_q == ST_SEND) begin
            if (ser_last) state_d = ST_IDLE;
        end else if (end_acc) begin
            state_d = ST_SEND;
        end else if (start_acc) begin
            state_d = ST_ACCUM;
        end
    end

    // State and latched mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_acc) mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/sigcrc_remainder.sv
// Remainder register shared by both check widths. In the narrow mode only
// the low WS bits are live: feedback comes from bit WS-1, and the upper
// bits are held at zero. It assumes WL > WS.
module sigcrc_remainder #(
    parameter int unsigned WL     = 8,
    parameter int unsigned WS     = 4,
    parameter logic [WL-1:0] POLY_L = 8'h07,
    parameter logic [WS-1:0] POLY_S = 4'h3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_short,
    input  logic          preset,
    input  logic          step_en,
    input  logic          din,
    output logic [WL-1:0] rem_nxt,
    output logic [WL-1:0] mask
);

    localparam logic [WL-1:0] MASK_S = {{(WL-WS){1'b0}}, {WS{1'b1}}};
    localparam logic [WL-1:0] POLY_SX = {{(WL-WS){1'b0}}, POLY_S};

    logic [WL-1:0] rem_q;
    logic [WL-1:0] base;
    logic [WL-1:0] shifted;
    logic          fb;

    // One division step on the preset or held remainder.
    always_comb begin
        mask    = use_short ? MASK_S : {WL{1'b1}};
        base    = preset ? mask : rem_q;
        fb      = (use_short ? base[WS-1] : base[WL-1]) ^ din;
        shifted = (base << 1) & mask;
        if (fb) shifted = shifted ^ (use_short ? POLY_SX : POLY_L);
        rem_nxt = step_en ? shifted : base;
    end

    // Remainder storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rem_q <= {WL{1'b1}};
        else if (preset || step_en) rem_q <= rem_nxt;
    end

endmodule

// File: rtl/sigcrc_serializer.sv
// Shifts a loaded check value out MSB first. The count of bits is set by
// the mode captured at load. It assumes that load arrives only while no
// value is being emitted.
module sigcrc_serializer #(
    parameter int unsigned WL = 8,
    parameter int unsigned WS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          use_short,
    input  logic [WL-1:0] value,
    output logic          out_valid,
    output logic          out_bit,
    output logic          out_last
);

    localparam int unsigned CW = $clog2(WL + 1);
    localparam logic [CW-1:0] N_L = CW'(WL);
    localparam logic [CW-1:0] N_S = CW'(WS);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [WL-1:0] sh_q;
    logic [CW-1:0] left_q;
    logic          short_q;

    // Output decode from the shift state.
    always_comb begin
        out_valid = (left_q != '0);
        out_last  = (left_q == ONE);
        out_bit   = short_q ? sh_q[WS-1] : sh_q[WL-1];
    end

    // Load or advance the shift register and remaining-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            left_q  <= '0;
            short_q <= 1'b0;
        end else if (load) begin
            sh_q    <= value;
            left_q  <= use_short ? N_S : N_L;
            short_q <= use_short;
        end else if (left_q != '0) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - ONE;
        end
    end

endmodule

// File: rtl/sig_crc_serial.sv
// Bit-serial header CRC generator with selectable 8-bit or 4-bit width.
// It assumes that mode_short is held from msg_start until crc_last.
module sig_crc_serial #(
    parameter int unsigned WL     = 8,
    parameter int unsigned WS     = 4,
    parameter logic [WL-1:0] POLY_L = 8'h07,
    parameter logic [WS-1:0] POLY_S = 4'h3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_short,
    input  logic msg_start,
    input  logic msg_valid,
    input  logic msg_bit,
    input  logic msg_end,
    output logic in_ready,
    output logic crc_valid,
    output logic crc_bit,
    output logic crc_last
);

    logic          start_acc;
    logic          step_en;
    logic          end_acc;
    logic          mode_eff;
    logic [WL-1:0] rem_nxt;
    logic [WL-1:0] mask;
    logic [WL-1:0] check_val;

    sigcrc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in   (mode_short),
        .msg_start (msg_start),
        .msg_valid (msg_valid),
        .msg_end   (msg_end),
        .ser_last  (crc_last),
        .accept    (in_ready),
        .start_acc (start_acc),
        .step_en   (step_en),
        .end_acc   (end_acc),
        .mode_eff  (mode_eff)
    );

    sigcrc_remainder #(
        .WL(WL), .WS(WS), .POLY_L(POLY_L), .POLY_S(POLY_S)
    ) u_rem (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_short (mode_eff),
        .preset    (start_acc),
        .step_en   (step_en),
        .din       (msg_bit),
        .rem_nxt   (rem_nxt),
        .mask      (mask)
    );

    // Final inversion of the remainder, confined to the live width.
    always_comb check_val = ~rem_nxt & mask;

    sigcrc_serializer #(
        .WL(WL), .WS(WS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (end_acc),
        .use_short (mode_eff),
        .value     (check_val),
        .out_valid (crc_valid),
        .out_bit   (crc_bit),
        .out_last  (crc_last)
    );

endmodule

// File: rtl/sigcrc_chk.sv
// Protocol checker for the serial header CRC generator, bound to the top.
// It assumes that mode_short is held during each output burst.
module sigcrc_chk #(
    parameter int unsigned WL = 8,
    parameter int unsigned WS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic mode_short,
    input logic msg_start,
    input logic msg_valid,
    input logic msg_end,
    input logic in_ready,
    input logic crc_valid,
    input logic crc_last
);

    int unsigned burst_cnt;

    // Counts the bits of the current output burst.
    always_ff @(posedge clk) begin
        if (!rst_n)         burst_cnt <= 0;
        else if (crc_valid) burst_cnt <= crc_last ? 0 : burst_cnt + 1;
    end

    assert_ready_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == !crc_valid);

    assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        crc_last |-> crc_valid);

    assert_burst_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        crc_last |=> !crc_valid);

    assert_burst_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_valid && !crc_last) |=> crc_valid);

    assert_burst_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_last && !mode_short) |-> (burst_cnt + 1 == WL));

    assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_last && mode_short) |-> (burst_cnt + 1 == WS));

    assert_start_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && in_ready && msg_start) |=> crc_valid);

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!crc_valid && in_ready));

endmodule

bind sig_crc_serial sigcrc_chk #(.WL(WL), .WS(WS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_short (mode_short),
    .msg_start  (msg_start),
    .msg_valid  (msg_valid),
    .msg_end    (msg_end),
    .in_ready   (in_ready),
    .crc_valid  (crc_valid),
    .crc_last   (crc_last)
);

// File: tb/sim_sig_crc_serial.sv
module sim_sig_crc_serial;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_short = 1'b0;
    logic msg_start = 1'b0;
    logic msg_valid = 1'b0;
    logic msg_bit = 1'b0;
    logic msg_end = 1'b0;
    logic in_ready, crc_valid, crc_bit, crc_last;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sig_crc_serial u0 (
        .clk(clk), .rst_n(rst_n), .mode_short(mode_short),
        .msg_start(msg_start), .msg_valid(msg_valid), .msg_bit(msg_bit),
        .msg_end(msg_end), .in_ready(in_ready), .crc_valid(crc_valid),
        .crc_bit(crc_bit), .crc_last(crc_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-level model: preset ones, polynomial step, final inversion.
    function automatic logic [7:0] crc_model(input bit sh, input logic [63:0] m, input int len);
        logic [7:0] r, mk, pl;
        int w;
        bit fb;
        w  = sh ? 4 : 8;
        mk = sh ? 8'h0F : 8'hFF;
        pl = sh ? 8'h03 : 8'h07;
        r  = mk;
        for (int i = 0; i < len; i++) begin
            fb = r[w-1] ^ m[i];
            r  = (r << 1) & mk;
            if (fb) r = r ^ pl;
        end
        return ~r & mk;
    endfunction

    task automatic idle_inputs();
        msg_start = 0; msg_valid = 0; msg_end = 0; msg_bit = 0;
    endtask

    // Receive one burst and compare it with the expected value.
    task automatic collect(input bit sh, input logic [7:0] exp, input bit garbage, input string req);
        int w;
        logic [7:0] got;
        bit shape_ok;
        w = sh ? 4 : 8;
        got = 0;
        shape_ok = 1;
        chk(crc_valid === 1'b1, "R4 valid after end", int'(crc_valid), 1);
        for (int k = 0; k < w; k++) begin
            if (garbage) begin
                msg_start = 1; msg_valid = 1; msg_end = 1; msg_bit = $urandom_range(0, 1);
            end else idle_inputs();
            if (crc_valid !== 1'b1 || in_ready !== 1'b0 || crc_last !== (k == w-1)) shape_ok = 0;
            got = {got[6:0], crc_bit};
            @(negedge clk);
        end
        idle_inputs();
        chk(shape_ok, "R3 burst shape", int'(shape_ok), 1);
        chk(got == exp, req, int'(got), int'(exp));
        chk(crc_valid === 1'b0 && in_ready === 1'b1, "R5 idle after burst",
            int'({crc_valid, in_ready}), 1);
    endtask

    // Feed one message, optionally with idle gaps, then check the result.
    task automatic run_msg(input bit sh, input logic [63:0] m, input int len,
                           input bit gaps, input bit garbage, input string req);
        mode_short = sh;
        if (len == 0) begin
            msg_start = 1; msg_end = 1; msg_valid = 0;
            @(negedge clk);
        end else begin
            for (int i = 0; i < len; i++) begin
                if (gaps && i > 0 && $urandom_range(0, 3) == 0) begin
                    idle_inputs();
                    @(negedge clk);
                end
                msg_start = (i == 0); msg_valid = 1; msg_bit = m[i]; msg_end = (i == len-1);
                @(negedge clk);
            end
        end
        idle_inputs();
        collect(sh, crc_model(sh, m, len), garbage, req);
    endtask

    initial begin
        logic [63:0] m;
        int len;
        logic [63:0] hdr;
        hdr = 64'h0;
        hdr[23:0] = 24'b000000110010010010001111;
        void'($urandom(32'd20241));
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(crc_valid === 1'b0 && in_ready === 1'b1, "R9 reset state", int'({crc_valid, in_ready}), 1);
        rst_n = 1;
        @(negedge clk);

        // R9: valid and end without start in idle produce nothing.
        msg_valid = 1; msg_end = 1; msg_bit = 1;
        @(negedge clk);
        idle_inputs();
        chk(crc_valid === 1'b0, "R9 stray end ignored", int'(crc_valid), 0);
        @(negedge clk);
        chk(crc_valid === 1'b0, "R9 stray end ignored", int'(crc_valid), 0);

        // R7: empty messages.
        run_msg(0, 64'h0, 0, 0, 0, "R7 empty 8-bit");
        run_msg(1, 64'h0, 0, 0, 0, "R7 empty 4-bit");
        // R6: single bit given with the start strobe.
        run_msg(0, 64'h1, 1, 0, 0, "R6 R1 single bit one");
        run_msg(0, 64'h0, 1, 0, 0, "R6 R1 single bit zero");
        run_msg(1, 64'h1, 1, 0, 0, "R6 R2 single bit one");
        run_msg(1, 64'h0, 1, 0, 0, "R6 R2 single bit zero");
        // 24-bit header in both widths.
        run_msg(0, hdr, 24, 0, 0, "R1 24-bit header");
        run_msg(1, hdr, 24, 0, 0, "R2 24-bit header");
        // R5: inputs driven during the output burst.
        run_msg(0, hdr, 24, 0, 1, "R5 busy inputs 8-bit");
        run_msg(1, hdr, 24, 0, 1, "R5 busy inputs 4-bit");

        // R8: restart an open message.
        mode_short = 0;
        for (int i = 0; i < 5; i++) begin
            msg_start = (i == 0); msg_valid = 1; msg_bit = $urandom_range(0, 1); msg_end = 0;
            @(negedge clk);
        end
        m = {$urandom, $urandom};
        for (int i = 0; i < 10; i++) begin
            msg_start = (i == 0); msg_valid = 1; msg_bit = m[i]; msg_end = (i == 9);
            @(negedge clk);
        end
        idle_inputs();
        collect(0, crc_model(0, m, 10), 0, "R8 restart discards bits");

        // Random lengths and gaps in both widths.
        for (int t = 0; t < 40; t++) begin
            m = {$urandom, $urandom};
            len = $urandom_range(1, 64);
            run_msg(t[0], m, len, t[1], 0, t[0] ? "R2 random" : "R1 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule